// File: doc/BRIEF.md
# SIMD First-Negative-Lane Index Inserter

This unit executes one family of vector operations on a 128-bit SIMD datapath. It scans a source vector upward from lane 0 to find the first lane that holds a negative signed value, meaning a lane whose top bit is set. It then writes that lane number into a single lane of the destination vector. Every other destination lane keeps the value it had before. If no lane is negative, the value written is the lane count.

The unit supports byte lanes (16 lanes of 8 bits) and halfword lanes (8 lanes of 16 bits). The destination lane can come from two places. In the register form it is taken from the low bits of lane 0 of a second source vector. In the immediate form it is a 5-bit field of the instruction word, wrapped to the lane count.

The caller presents the 32-bit instruction word, the old destination vector and both source vectors together with a valid strobe. One clock later the updated destination appears with its own valid strobe. A word that matches none of the four supported encodings raises an illegal flag and returns the old destination unchanged.

Top module: `simd_neg_index_insert`

## Requirements
- R1: In byte mode, the value written is the lowest lane number i (0 to 15) whose bit 8*i+7 of `src_a` is set.
- R2: When no lane of `src_a` has its top bit set, the value written is the lane count: 16 in byte mode and 8 in halfword mode. The value is zero-extended to the lane width.
- R3: In halfword mode, lanes are 16 bits wide. The value written is the lowest lane number i (0 to 7) whose bit 16*i+15 is set.
- R4: In the register form, the destination lane is `src_b[3:0]` in byte mode and `src_b[2:0]` in halfword mode. All higher bits of `src_b` are ignored.
- R5: In the immediate form, the destination lane is `instr[14:10]` modulo 16 in byte mode and modulo 8 in halfword mode.
- R6: Every lane other than the destination lane equals the same lane of `dst_old`.
- R7: `instr[31:15]` selects the form, and bits [14:0] do not take part in decoding:
  - 0111_00010010_10110 is register/byte.
  - 0111_00010010_10111 is register/halfword.
  - 0111_00101001_10100 is immediate/byte.
  - 0111_00101001_10101 is immediate/halfword.
- R8: For any other value of `instr[31:15]`, `illegal` is 1 and `dst_new` equals `dst_old`. For the four encodings in R7, `illegal` is 0.
- R9: The result, `illegal` and `out_valid` are registered. `out_valid` is 1 exactly one cycle after a cycle with `in_valid` high. While reset is asserted, `out_valid`, `illegal` and `dst_new` are 0.
- R10: After a cycle with `in_valid` low, `dst_new` and `illegal` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and instruction are valid this cycle |
| instr | input | 32 | Instruction word |
| dst_old | input | 128 | Old destination vector |
| src_a | input | 128 | Vector that is scanned for a negative lane |
| src_b | input | 128 | Lane-select source for the register form |
| out_valid | output | 1 | Result is valid |
| dst_new | output | 128 | Updated destination vector |
| illegal | output | 1 | Instruction word matched no supported encoding |

## Verification
The bench sweeps all four forms. For each form it steps every destination selector from 0 to 31 against every position of the first negative lane, including the case with no negative lane.

- Lanes below that position are forced non-negative, which separates a true lowest-first search from a highest-first or any-lane search.
- Lanes above that position are random, so a search that is not lowest-first gives a wrong answer.
- The selector sweep runs past the lane count. This exposes missing masking of `src_b` and a wrong wrap of the immediate.
- A negative value only in the top lane, and the no-negative case, catch an off-by-one at the end of the scan.
- Near-miss and random instruction words check that illegal words pass the old destination through.
- Idle cycles with changed inputs check that the output holds.

// File: rtl/fnl_pkg.sv
package fnl_pkg;

   localparam logic [16:0] ENC_REG_BYTE = 17'b0111_00010010_10110;
   localparam logic [16:0] ENC_REG_HALF = 17'b0111_00010010_10111;
   localparam logic [16:0] ENC_IMM_BYTE = 17'b0111_00101001_10100;
   localparam logic [16:0] ENC_IMM_HALF = 17'b0111_00101001_10101;

   typedef struct packed {
      logic       legal;
      logic       half;
      logic       use_imm;
      logic [4:0] fld_k;
   } fnl_dec_t;

endpackage

// File: rtl/fnl_decode.sv
module fnl_decode
   import fnl_pkg::*;
(
   input  logic [31:10] instr_hi,
   output fnl_dec_t     dec
);

   always_comb begin
      dec.legal   = 1'b1;
      dec.half    = 1'b0;
      dec.use_imm = 1'b0;
      dec.fld_k   = instr_hi[14:10];
      unique case (instr_hi[31:15])
         ENC_REG_BYTE: begin dec.half = 1'b0; dec.use_imm = 1'b0; end
         ENC_REG_HALF: begin dec.half = 1'b1; dec.use_imm = 1'b0; end
         ENC_IMM_BYTE: begin dec.half = 1'b0; dec.use_imm = 1'b1; end
         ENC_IMM_HALF: begin dec.half = 1'b1; dec.use_imm = 1'b1; end
         default:      dec.legal = 1'b0;
      endcase
   end

   // R7: a legal decode must come from one of exactly four opcode prefixes
   always_comb begin
      if (dec.legal) begin
         a_r7_legal_prefix: assert (instr_hi[31:25] == 7'b0111_000 || instr_hi[31:25] == 7'b0111_001);
      end
   end

endmodule

// File: rtl/fnl_scan.sv
module fnl_scan #(
   parameter int VEC_W  = 128,
   parameter int LANE_W = 8,
   localparam int LANES = VEC_W / LANE_W,
   localparam int IDX_W = $clog2(LANES) + 1
) (
   input  logic [VEC_W-1:0] vec,
   output logic [IDX_W-1:0] idx
);

   logic [LANES-1:0] neg;

   generate
      if (VEC_W % LANE_W != 0) begin : g_bad_div
         $error("fnl_scan: VEC_W must be a multiple of LANE_W");
      end
      if (LANE_W < 2) begin : g_bad_lane
         $error("fnl_scan: LANE_W must be at least 2");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign neg[g] = vec[g*LANE_W + LANE_W - 1];
         wire unused_mag = ^vec[g*LANE_W +: LANE_W-1];
      end
   endgenerate

   always_comb begin
      idx = IDX_W'(LANES);
      for (int i = LANES - 1; i >= 0; i--) begin
         if (neg[i]) idx = IDX_W'(i);
      end
   end

   // R1/R3: a found index points at a negative lane with none below it
   always_comb begin
      if (idx != IDX_W'(LANES)) begin
         a_r1_first_negative: assert (neg[idx[IDX_W-2:0]] &&
            ((neg & ~({LANES{1'b1}} << idx)) == '0));
      end
   end

   // R2: the lane count is only reported when no lane is negative
   always_comb begin
      if (idx == IDX_W'(LANES)) begin
         a_r2_none_negative: assert (neg == '0);
      end
   end

endmodule

// File: rtl/fnl_insert.sv
module fnl_insert #(
   parameter int VEC_W  = 128,
   parameter int LANE_W = 8,
   localparam int LANES = VEC_W / LANE_W,
   localparam int SEL_W = $clog2(LANES),
   localparam int IDX_W = SEL_W + 1
) (
   input  logic [VEC_W-1:0] old_vec,
   input  logic [SEL_W-1:0] sel,
   input  logic [IDX_W-1:0] idx,
   output logic [VEC_W-1:0] new_vec
);

   logic [LANES-1:0] changed;

   generate
      if (IDX_W > LANE_W) begin : g_bad_idx
         $error("fnl_insert: lane too narrow for the index value");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign new_vec[g*LANE_W +: LANE_W] =
            (sel == SEL_W'(g)) ? LANE_W'(idx) : old_vec[g*LANE_W +: LANE_W];
         assign changed[g] = new_vec[g*LANE_W +: LANE_W] != old_vec[g*LANE_W +: LANE_W];
      end
   endgenerate

   // R6: at most one lane may differ from the old vector
   always_comb begin
      a_r6_single_lane: assert ($countones(changed) <= 1);
   end

endmodule

// File: rtl/simd_neg_index_insert.sv
module simd_neg_index_insert
   import fnl_pkg::*;
#(
   parameter int VEC_W  = 128,
   parameter int BYTE_W = 8,
   parameter int HALF_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [31:0]      instr,
   input  logic [VEC_W-1:0] dst_old,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   output logic             out_valid,
   output logic [VEC_W-1:0] dst_new,
   output logic             illegal
);

   localparam int SEL_MAX = $clog2(VEC_W / BYTE_W);

   fnl_dec_t         dec;
   logic [VEC_W-1:0] cand [2];
   logic [VEC_W-1:0] result;

   generate
      if ((VEC_W / BYTE_W) & ((VEC_W / BYTE_W) - 1)) begin : g_bad_pow2
         $error("simd_neg_index_insert: byte lane count must be a power of two");
      end
      if (SEL_MAX > 4) begin : g_bad_imm
         $error("simd_neg_index_insert: lane count exceeds the 5-bit immediate range");
      end
      if (HALF_W != 2 * BYTE_W) begin : g_bad_half
         $error("simd_neg_index_insert: HALF_W must be twice BYTE_W");
      end
   endgenerate

   fnl_decode u_dec (
      .instr_hi (instr[31:10]),
      .dec      (dec)
   );

   generate
      for (genvar s = 0; s < 2; s++) begin : g_size
         localparam int LW = (s == 0) ? BYTE_W : HALF_W;
         localparam int LN = VEC_W / LW;
         localparam int SW = $clog2(LN);

         logic [SW:0]   idx;
         logic [SW-1:0] sel;

         fnl_scan #(.VEC_W(VEC_W), .LANE_W(LW)) u_scan (
            .vec (src_a),
            .idx (idx)
         );

         // masking the lane-0 bits and wrapping the immediate both reduce to low bits
         assign sel = dec.use_imm ? dec.fld_k[SW-1:0] : src_b[SW-1:0];

         fnl_insert #(.VEC_W(VEC_W), .LANE_W(LW)) u_ins (
            .old_vec (dst_old),
            .sel     (sel),
            .idx     (idx),
            .new_vec (cand[s])
         );
      end
   endgenerate

   assign result = !dec.legal ? dst_old : (dec.half ? cand[1] : cand[0]);

   wire unused_bits = ^{instr[9:0], src_b[VEC_W-1:SEL_MAX], dec.fld_k[4:SEL_MAX]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         dst_new   <= '0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            dst_new <= result;
            illegal <= !dec.legal;
         end
      end
   end

   // R9: output valid trails input valid by exactly one cycle
   a_r9_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid)));

   // R8: an illegal word returns the old destination untouched
   a_r8_illegal_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && illegal) |-> (dst_new == $past(dst_old)));

   // R10: idle cycles leave the output unchanged
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(in_valid)) |-> ($stable(dst_new) && $stable(illegal)));

endmodule

// File: tb/tb_simd_neg_index_insert.sv
`timescale 1ns/1ps
module tb_simd_neg_index_insert;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [31:0]  instr = '0;
   logic [127:0] dst_old = '0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic         out_valid;
   logic [127:0] dst_new;
   logic         illegal;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   simd_neg_index_insert dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .dst_old(dst_old), .src_a(src_a), .src_b(src_b),
      .out_valid(out_valid), .dst_new(dst_new), .illegal(illegal)
   );

   localparam logic [16:0] P_RB = 17'b0111_00010010_10110;
   localparam logic [16:0] P_RH = 17'b0111_00010010_10111;
   localparam logic [16:0] P_IB = 17'b0111_00101001_10100;
   localparam logic [16:0] P_IH = 17'b0111_00101001_10101;

   function automatic logic [127:0] model(input logic [31:0] ins, input logic [127:0] old,
                                          input logic [127:0] a, input logic [127:0] b,
                                          output logic ill);
      logic legal, half, imm;
      int w, n, first, sel;
      logic [127:0] o;
      legal = 1'b1; half = 1'b0; imm = 1'b0;
      case (ins[31:15])
         P_RB: begin half = 0; imm = 0; end
         P_RH: begin half = 1; imm = 0; end
         P_IB: begin half = 0; imm = 1; end
         P_IH: begin half = 1; imm = 1; end
         default: legal = 1'b0;
      endcase
      ill = !legal;
      if (!legal) return old;
      w = half ? 16 : 8;
      n = 128 / w;
      first = n;
      for (int i = n - 1; i >= 0; i--) if (a[i*w + w - 1]) first = i;
      sel = imm ? int'(ins[14:10]) % n : int'(b[15:0]) % n;
      o = old;
      for (int k = 0; k < w; k++) o[sel*w + k] = first[k];
      return o;
   endfunction

   task automatic check(input string tag, input logic [127:0] exp_v, input logic exp_ill);
      checks++;
      if (out_valid !== 1'b1 || dst_new !== exp_v || illegal !== exp_ill) begin
         errors++;
         $display("FAIL %s: got valid=%b ill=%b data=%h, expected valid=1 ill=%b data=%h",
                  tag, out_valid, illegal, dst_new, exp_ill, exp_v);
      end
   endtask

   // one operation, then one idle cycle with changed inputs (R9, R10)
   task automatic run_op(input logic [31:0] ins, input logic [127:0] old,
                         input logic [127:0] a, input logic [127:0] b, input string tag);
      logic [127:0] exp_v;
      logic exp_ill;
      exp_v = model(ins, old, a, b, exp_ill);
      instr = ins; dst_old = old; src_a = a; src_b = b; in_valid = 1'b1;
      @(negedge clk);
      check(tag, exp_v, exp_ill);
      in_valid = 1'b0;
      dst_old = ~old; src_a = ~a; instr = ~ins;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || dst_new !== exp_v || illegal !== exp_ill) begin
         errors++;
         $display("FAIL R10 hold: got valid=%b data=%h, expected valid=0 data=%h",
                  out_valid, dst_new, exp_v);
      end
   endtask

   initial begin
      #(8ns * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [16:0] pre [4];
      pre[0] = P_RB; pre[1] = P_RH; pre[2] = P_IB; pre[3] = P_IH;

      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || illegal !== 1'b0 || dst_new !== '0) begin
         errors++;
         $display("FAIL R9 reset: got valid=%b ill=%b data=%h, expected 0 0 0",
                  out_valid, illegal, dst_new);
      end
      rst_n = 1'b1;
      @(negedge clk);

      for (int f = 0; f < 4; f++) begin
         for (int s = 0; s < 32; s++) begin
            int w, n;
            w = (f % 2 == 1) ? 16 : 8;
            n = 128 / w;
            for (int p = 0; p <= n; p++) begin
               logic [127:0] a, b, old;
               logic [31:0] ins;
               string tag;
               a = {$urandom, $urandom, $urandom, $urandom};
               for (int l = 0; l < n; l++) begin
                  if (l < p) a[l*w + w - 1] = 1'b0;
                  else if (l == p) a[l*w + w - 1] = 1'b1;
               end
               if (p == n - 1 && (s % 2 == 0)) begin
                  // only the top lane negative
                  for (int l = 0; l < n - 1; l++) a[l*w + w - 1] = 1'b0;
               end
               b = {$urandom, $urandom, $urandom, $urandom};
               b[4:0] = 5'(s);
               old = {$urandom, $urandom, $urandom, $urandom};
               ins = {pre[f], 5'(s), 10'($urandom)};
               tag = $sformatf("%s%s/%s/R6/R7 form=%0d sel=%0d neg=%0d",
                               (w == 16) ? "R3" : "R1", (p == n) ? "/R2" : "",
                               (f >= 2) ? "R5" : "R4", f, s, p);
               run_op(ins, old, a, b, tag);
            end
         end
      end

      // R8: near-miss and random illegal words
      for (int k = 0; k < 17; k++) begin
         logic [31:0] ins;
         ins = {P_RB ^ (17'd1 << k), 15'($urandom)};
         if (ins[31:15] == P_RH) ins[31] = ~ins[31];
         run_op(ins, {$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom},
                $sformatf("R8 near-miss bit=%0d", k));
      end
      for (int k = 0; k < 40; k++) begin
         logic [31:0] ins;
         ins = $urandom;
         if (ins[31:28] == 4'b0111) ins[31] = 1'b1;
         run_op(ins, {$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom}, "R8 random word");
      end

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule